// File: doc/BRIEF.md
# Dual-Speed Clock Switch Controller

This block selects whether the processor side of the system runs at its normal machine-cycle rate or at twice that rate. Software arms a change by setting a bit in a small control register. The change happens only when the core signals, through a one-cycle strobe, that it has executed its stop instruction. The controller then flips the speed select, clears the arming bit and holds the processor in a halt for a fixed settling pause. The divider is frozen for the length of that pause.

The block also derives one clock-enable pulse train per subsystem from a single fast master clock. The processor, the timer/divider, the serial port and the object-attribute copy engine follow the selected speed. The video controller, the video-memory copy engine and the audio section always tick at the base rate. It generates no clocks itself; it only qualifies the master clock.

Top module: `speed_switch_ctrl`

## Requirements
- R1: After reset the speed select is 0 (normal), the arming bit is 0, the halt output is low and the register reads 8'h7E.
- R2: The register read value has the current speed in bit 7, the arming bit in bit 0 and 1 in bits 6 to 1. A write updates only bit 0 from data bit 0, and bit 7 ignores writes.
- R3: A stop strobe sampled while the arming bit is 1 and no pause is running toggles the speed select and clears the arming bit. Both take effect on the next clock edge.
- R4: A stop strobe sampled while the arming bit is 0 leaves the speed, the arming bit and the halt output unchanged.
- R5: The halt output rises on the edge that takes a switching stop strobe and stays high for exactly PAUSE_CLKS master clocks (default 8200).
- R6: While halt is high, the processor and timer/divider enables stay low.
- R7: The processor, timer, serial and object-copy enables pulse once every NORM_PERIOD clocks at normal speed and twice every NORM_PERIOD clocks at double speed (default NORM_PERIOD 4). The processor and timer enables are gated by R6.
- R8: The video, video-memory copy and audio enables pulse once every NORM_PERIOD clocks at either speed, including during the pause.
- R9: During a pause, a stop strobe has no effect, even with the arming bit set. Register writes may change the arming bit but cannot end the pause.
- R10: When a write and a stop strobe fall in the same cycle, the stop strobe acts on the arming bit held before that edge. If that bit was 1, the switch happens and the arming bit ends at 0. If it was 0, no switch occurs and the written bit 0 is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock (double-speed machine rate times NORM_PERIOD/2) |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read value |
| stop_strobe | input | 1 | One-cycle pulse when the core executes stop |
| speed_dbl | output | 1 | Current speed select, 1 = double |
| cpu_halt | output | 1 | Processor hold during the settling pause |
| cpu_en | output | 1 | Processor machine-cycle enable |
| timer_en | output | 1 | Timer/divider enable |
| serial_en | output | 1 | Serial port enable |
| oamdma_en | output | 1 | Object-attribute copy enable |
| video_en | output | 1 | Video controller enable |
| vramdma_en | output | 1 | Video-memory copy enable |
| audio_en | output | 1 | Audio enable |

## Verification
A register write and a stop strobe can land in the same cycle, and the outcome depends on which one the arming bit obeys. The bench drives both on one edge, once with the arming bit clear and once with it set. It then judges the next cycle by the read value, the speed select and the halt output. It also sends a stop strobe and an arming write during a running pause, then checks that the pause still lasts exactly its full length and that the speed stays unchanged.

// File: rtl/spdsw_pkg.sv
package spdsw_pkg;
   typedef enum int unsigned {
      DOM_CPU  = 0,
      DOM_TMR  = 1,
      DOM_SER  = 2,
      DOM_OAM  = 3,
      DOM_VID  = 4,
      DOM_VDMA = 5,
      DOM_AUD  = 6
   } dom_e;

   localparam int unsigned N_DOM = 7;
   // domains that follow the selected speed
   localparam logic [N_DOM-1:0] DOM_SCALED = 7'b000_1111;
   // domains frozen during the settling pause
   localparam logic [N_DOM-1:0] DOM_HALTED = 7'b000_0011;
endpackage

// File: rtl/spdsw_ctrl_reg.sv
module spdsw_ctrl_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic wr_arm,
   input  logic stop_i,
   input  logic halt_i,
   output logic trig_o,
   output logic speed_o,
   output logic arm_o
);
   logic speed_q, arm_q;

   assign trig_o  = stop_i & arm_q & ~halt_i;
   assign speed_o = speed_q;
   assign arm_o   = arm_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         speed_q <= 1'b0;
         arm_q   <= 1'b0;
      end else if (trig_o) begin
         speed_q <= ~speed_q;
         arm_q   <= 1'b0;
      end else if (wr_en) begin
         arm_q   <= wr_arm;
      end
   end

   a_r3_speed_moves_on_trig: assert property (@(posedge clk) disable iff (!rst_n)
      (speed_q != $past(speed_q)) |-> $past(trig_o));
   a_r3_arm_clears: assert property (@(posedge clk) disable iff (!rst_n)
      trig_o |=> !arm_q);
   a_r4_unarmed_stop_keeps_speed: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_i && !arm_q) |=> $stable(speed_q));
endmodule

// File: rtl/spdsw_pause.sv
module spdsw_pause #(
   parameter int unsigned PAUSE_CLKS = 8200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig_i,
   output logic halt_o
);
   localparam int unsigned CNT_W = (PAUSE_CLKS > 1) ? $clog2(PAUSE_CLKS) : 1;

   generate
      if (PAUSE_CLKS < 2) begin : g_bad_pause
         $error("PAUSE_CLKS must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic             halt_q;

   assign halt_o = halt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         halt_q <= 1'b0;
         cnt_q  <= '0;
      end else if (trig_i && !halt_q) begin
         halt_q <= 1'b1;
         cnt_q  <= CNT_W'(PAUSE_CLKS - 1);
      end else if (halt_q) begin
         if (cnt_q == '0) halt_q <= 1'b0;
         else             cnt_q  <= cnt_q - 1'b1;
      end
   end

   a_r5_halt_follows_trig: assert property (@(posedge clk) disable iff (!rst_n)
      trig_i |=> halt_q);
   a_r9_release_by_count: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(halt_q) |-> ($past(cnt_q) == '0));
endmodule

// File: rtl/spdsw_clk_en.sv
module spdsw_clk_en
   import spdsw_pkg::*;
#(
   parameter int unsigned NORM_PERIOD = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             speed_i,
   input  logic             halt_i,
   output logic [N_DOM-1:0] en_o
);
   localparam int unsigned PH_W = (NORM_PERIOD > 1) ? $clog2(NORM_PERIOD) : 1;
   localparam int unsigned HALF = NORM_PERIOD / 2;

   generate
      if (NORM_PERIOD < 2 || (NORM_PERIOD % 2) != 0) begin : g_bad_period
         $error("NORM_PERIOD must be even and at least 2");
      end
   endgenerate

   logic [PH_W-1:0] ph_q;
   logic            base_tick, fast_tick;

   always_ff @(posedge clk) begin
      if (!rst_n)                             ph_q <= '0;
      else if (ph_q == PH_W'(NORM_PERIOD - 1)) ph_q <= '0;
      else                                    ph_q <= ph_q + 1'b1;
   end

   assign base_tick = (ph_q == PH_W'(NORM_PERIOD - 1));
   assign fast_tick = base_tick | (ph_q == PH_W'(HALF - 1));

   for (genvar i = 0; i < N_DOM; i++) begin : g_dom
      logic tick;
      if (DOM_SCALED[i]) begin : g_scaled
         assign tick = speed_i ? fast_tick : base_tick;
      end else begin : g_fixed
         assign tick = base_tick;
      end
      if (DOM_HALTED[i]) begin : g_gated
         assign en_o[i] = tick & ~halt_i;
      end else begin : g_free
         assign en_o[i] = tick;
      end
   end
endmodule

// File: rtl/speed_switch_ctrl.sv
module speed_switch_ctrl
   import spdsw_pkg::*;
#(
   parameter int unsigned NORM_PERIOD = 4,
   parameter int unsigned PAUSE_CLKS  = 8200,
   parameter int unsigned SPEED_BIT   = 7,
   parameter int unsigned ARM_BIT     = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       reg_wr,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   input  logic       stop_strobe,
   output logic       speed_dbl,
   output logic       cpu_halt,
   output logic       cpu_en,
   output logic       timer_en,
   output logic       serial_en,
   output logic       oamdma_en,
   output logic       video_en,
   output logic       vramdma_en,
   output logic       audio_en
);
   localparam int unsigned REG_W = 8;

   generate
      if (SPEED_BIT >= REG_W || ARM_BIT >= REG_W || SPEED_BIT == ARM_BIT) begin : g_bad_bits
         $error("SPEED_BIT and ARM_BIT must be distinct positions inside the register");
      end
   endgenerate

   logic             trig, speed, arm, halt;
   logic [N_DOM-1:0] en;

   spdsw_ctrl_reg u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_wr),
      .wr_arm  (reg_wdata[ARM_BIT]),
      .stop_i  (stop_strobe),
      .halt_i  (halt),
      .trig_o  (trig),
      .speed_o (speed),
      .arm_o   (arm)
   );

   spdsw_pause #(.PAUSE_CLKS(PAUSE_CLKS)) u_pause (
      .clk    (clk),
      .rst_n  (rst_n),
      .trig_i (trig),
      .halt_o (halt)
   );

   spdsw_clk_en #(.NORM_PERIOD(NORM_PERIOD)) u_en (
      .clk     (clk),
      .rst_n   (rst_n),
      .speed_i (speed),
      .halt_i  (halt),
      .en_o    (en)
   );

   always_comb begin
      reg_rdata            = '1;
      reg_rdata[SPEED_BIT] = speed;
      reg_rdata[ARM_BIT]   = arm;
   end

   assign speed_dbl  = speed;
   assign cpu_halt   = halt;
   assign cpu_en     = en[DOM_CPU];
   assign timer_en   = en[DOM_TMR];
   assign serial_en  = en[DOM_SER];
   assign oamdma_en  = en[DOM_OAM];
   assign video_en   = en[DOM_VID];
   assign vramdma_en = en[DOM_VDMA];
   assign audio_en   = en[DOM_AUD];

   a_r6_timer_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_halt |-> (!timer_en && !cpu_en));
   a_r8_video_spaced: assert property (@(posedge clk) disable iff (!rst_n)
      video_en |=> !video_en);
   a_r7_serial_spaced: assert property (@(posedge clk) disable iff (!rst_n)
      serial_en |=> !serial_en);
   a_r9_stop_ignored_in_pause: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_halt && stop_strobe) |=> $stable(speed_dbl));
endmodule

// File: tb/speed_switch_ctrl_tb.sv
module speed_switch_ctrl_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       stop_strobe = 1'b0;
   logic       speed_dbl, cpu_halt;
   logic       cpu_en, timer_en, serial_en, oamdma_en, video_en, vramdma_en, audio_en;

   localparam int PAUSE = 8200;

   always #5 clk = ~clk;

   speed_switch_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .stop_strobe(stop_strobe), .speed_dbl(speed_dbl),
      .cpu_halt(cpu_halt), .cpu_en(cpu_en), .timer_en(timer_en),
      .serial_en(serial_en), .oamdma_en(oamdma_en), .video_en(video_en),
      .vramdma_en(vramdma_en), .audio_en(audio_en)
   );

   typedef struct {
      string req;
      int    sel;   // 0 rdata, 1 halt, 2 speed, 9 measured value
      int    exp;
      int    act;
   } item_t;

   item_t q[$];
   int n_chk = 0, n_fail = 0;
   int cnt[7];
   bit done = 0;

   task automatic push_port(string req, int sel, int exp);
      item_t it;
      it.req = req; it.sel = sel; it.exp = exp; it.act = 0;
      q.push_back(it);
   endtask

   task automatic push_val(string req, int act, int exp);
      item_t it;
      it.req = req; it.sel = 9; it.exp = exp; it.act = act;
      q.push_back(it);
   endtask

   // monitor: drains expectations one time unit after each falling edge
   initial begin
      forever begin
         @(negedge clk);
         #1;
         while (q.size() > 0) begin
            item_t it;
            int a;
            it = q.pop_front();
            case (it.sel)
               0:       a = int'(reg_rdata);
               1:       a = int'(cpu_halt);
               2:       a = int'(speed_dbl);
               default: a = it.act;
            endcase
            n_chk++;
            if (a != it.exp) begin
               n_fail++;
               $display("FAIL %s sel=%0d actual=%0h expected=%0h", it.req, it.sel, a, it.exp);
            end
         end
      end
   end

   task automatic wr(input logic [7:0] d);
      @(negedge clk); reg_wr = 1'b1; reg_wdata = d;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic count_window(int len);
      for (int k = 0; k < 7; k++) cnt[k] = 0;
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         cnt[0] += int'(cpu_en);    cnt[1] += int'(timer_en);
         cnt[2] += int'(serial_en); cnt[3] += int'(oamdma_en);
         cnt[4] += int'(video_en);  cnt[5] += int'(vramdma_en);
         cnt[6] += int'(audio_en);
      end
   endtask

   task automatic wait_pause_end();
      while (cpu_halt) @(negedge clk);
   endtask

   initial begin
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      push_port("R1 rdata", 0, 8'h7E);
      push_port("R1 halt", 1, 0);
      push_port("R1 speed", 2, 0);

      // R7 / R8 at normal speed
      count_window(16);
      push_val("R7 cpu normal", cnt[0], 4);
      push_val("R7 serial normal", cnt[2], 4);
      push_val("R8 video normal", cnt[4], 4);

      // R2 register layout and write masking
      wr(8'hFE); push_port("R2 write FE", 0, 8'h7E);
      wr(8'h01); push_port("R2 write 01", 0, 8'h7F);
      wr(8'h80); push_port("R2 bit7 ignores write", 0, 8'h7E);

      // R4 unarmed stop
      @(negedge clk); stop_strobe = 1'b1;
      @(negedge clk); stop_strobe = 1'b0;
      push_port("R4 rdata", 0, 8'h7E);
      push_port("R4 halt", 1, 0);

      // R3 armed stop
      wr(8'h01);
      @(negedge clk); stop_strobe = 1'b1;
      @(negedge clk); stop_strobe = 1'b0;
      push_port("R3 rdata", 0, 8'hFE);
      push_port("R3 speed", 2, 1);
      push_port("R5 halt rises", 1, 1);
      n = 1;
      for (int k = 0; k < 7; k++) cnt[k] = 0;
      while (cpu_halt) begin
         @(negedge clk);
         reg_wr = 1'b0; stop_strobe = 1'b0;
         if (n <= 16) begin
            cnt[0] += int'(cpu_en);    cnt[1] += int'(timer_en);
            cnt[2] += int'(serial_en); cnt[4] += int'(video_en);
         end
         if (n == 100) begin reg_wr = 1'b1; reg_wdata = 8'h01; end
         if (n == 200) stop_strobe = 1'b1;
         if (cpu_halt) n++;
      end
      push_val("R6 cpu quiet in pause", cnt[0], 0);
      push_val("R6 timer quiet in pause", cnt[1], 0);
      push_val("R7 serial double in pause", cnt[2], 8);
      push_val("R8 video base in pause", cnt[4], 4);
      push_val("R5 pause length", n, PAUSE);
      push_port("R9 speed kept, arm kept", 0, 8'hFF);

      // R7 / R8 at double speed
      count_window(16);
      push_val("R7 cpu double", cnt[0], 8);
      push_val("R7 timer double", cnt[1], 8);
      push_val("R7 oamdma double", cnt[3], 8);
      push_val("R8 vramdma base", cnt[5], 4);
      push_val("R8 audio base", cnt[6], 4);

      // R10 write and stop together, arm set
      @(negedge clk); reg_wr = 1'b1; reg_wdata = 8'h01; stop_strobe = 1'b1;
      @(negedge clk); reg_wr = 1'b0; stop_strobe = 1'b0;
      push_port("R10 armed collide rdata", 0, 8'h7E);
      push_port("R10 armed collide halt", 1, 1);
      wait_pause_end();
      @(negedge clk);

      // R10 write and stop together, arm clear
      @(negedge clk); reg_wr = 1'b1; reg_wdata = 8'h01; stop_strobe = 1'b1;
      @(negedge clk); reg_wr = 1'b0; stop_strobe = 1'b0;
      push_port("R10 unarmed collide rdata", 0, 8'h7F);
      push_port("R10 unarmed collide halt", 1, 0);
      push_port("R10 unarmed collide speed", 2, 0);

      repeat (3) @(negedge clk);
      done = 1;
   end

   initial begin
      int w = 0;
      while (!done && w < 60000) begin
         @(posedge clk);
         w++;
      end
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
      end
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule